// File: doc/BRIEF.md
# Attenuator Serial Programming Controller

This controller sits on the host side of a board and programs a serial step attenuator from a fast system clock. A six-bit attenuation code arrives on a valid/ready stream input. The controller shifts the code out on three plain pins: a serial clock, serial data and a latch strobe. The most significant bit goes first and carries the 16 dB weight. The 0.5 dB bit goes last. After the sixth bit, the controller raises the latch strobe once so the attenuator takes the new word. It then pulses a done flag.

Every phase length is a cycle count. Each count is derived from a system-clock period parameter and from nanosecond minima, also parameters: clock high, clock low, clock period, data setup, data hold, latch setup and latch width. Each count is rounded up so that the minimum is always met.

Back-pressure: `code_ready` is high only while the controller is idle. A word transfers on a cycle where both `code_valid` and `code_ready` are high. A source may hold `code_valid` with a stable code for as long as needed. Requests seen while `code_ready` is low are not captured.

Top module: `atten_serial_prog`

## Requirements
- R1: `code_ready` is high only in idle. A code is captured on a clock edge with `code_valid` and `code_ready` both high, and `code_ready` is low in the following cycle. A request made while `code_ready` is low is never captured.
- R2: After reset and whenever idle, `ser_clk`, `ser_data`, `ser_latch` and `word_done` are low, and `code_ready` is high.
- R3: Each accepted word produces exactly six rising edges of `ser_clk`. The bit sampled on edge k (k = 1..6) is `code_data[6-k]`, so bit 5 (16 dB) goes first and bit 0 (0.5 dB) goes last.
- R4: Each `ser_clk` high time and low time within a word is at least 30 ns. Rising edges within a word are at least 100 ns apart.
- R5: `ser_data` changes only while `ser_clk` is low. It is stable at least 10 ns before each rising edge, and it does not change until at least 10 ns after each falling edge.
- R6: `ser_latch` stays low during shifting. It rises once per word, only after the sixth rising edge of `ser_clk`.
- R7: `ser_latch` rises at least 10 ns after the last falling edge of `ser_clk`.
- R8: `ser_latch` stays high for at least 30 ns.
- R9: `word_done` is high for exactly one cycle: the first cycle in which `ser_latch` is low again after its pulse. `code_ready` returns high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Stream valid for the attenuation code |
| code_ready | output | 1 | Stream ready; high only when idle |
| code_data | input | CODE_W | Attenuation code, bit 5 = 16 dB weight |
| ser_clk | output | 1 | Serial clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_latch | output | 1 | Latch strobe to the attenuator |
| word_done | output | 1 | One-cycle pulse after the latch strobe falls |

## Verification
The bench drives two groups of codes. Codes with a single bit set (the 16 dB code and the 0.5 dB code) reveal any error in bit order or in the count of edges. The all-zeros, all-ones and alternating codes (2A and 15 in hex) reveal stuck data and data changing at the wrong phase. A source that holds valid high while the controller is busy checks that the held word is taken exactly once. A request pulsed and then withdrawn during a busy period must leave no extra latch pulse. A small attenuator model samples data on each rising clock edge and captures its shift register on the latch strobe. From the same samples, the bench measures every high time, low time, setup window, hold window and latch window in nanoseconds.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LSU   = 3'd4,
    ST_LHI   = 3'd5,
    ST_DONE  = 3'd6
  } prog_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/atten_bit_shifter.sv
module atten_bit_shifter #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             advance,
  output logic             msb,
  output logic             last_bit
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] word_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= load_word;
      idx_q  <= '0;
    end else if (advance) begin
      word_q <= {word_q[WIDTH-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign msb      = word_q[WIDTH-1];
  assign last_bit = (idx_q == IDX_W'(WIDTH - 1));
endmodule

// File: rtl/atten_serial_prog.sv
module atten_serial_prog
  import atten_prog_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYS_CLK_NS  = 10,
  parameter int MIN_HIGH_NS = 30,
  parameter int MIN_LOW_NS  = 30,
  parameter int MIN_PER_NS  = 100,
  parameter int SETUP_NS    = 10,
  parameter int HOLD_NS     = 10,
  parameter int LATCH_SU_NS = 10,
  parameter int LATCH_PW_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_data,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_latch,
  output logic              word_done
);
  localparam int PER_CYC = ceil_div(MIN_PER_NS, SYS_CLK_NS);
  localparam int HI_LEN  = max3(ceil_div(MIN_HIGH_NS, SYS_CLK_NS),
                                ceil_div(MIN_PER_NS, 2 * SYS_CLK_NS), 1);
  localparam int HD_LEN  = max3(ceil_div(HOLD_NS, SYS_CLK_NS), 1, 1);
  localparam int SU_LEN  = max3(ceil_div(SETUP_NS, SYS_CLK_NS),
                                PER_CYC - HI_LEN - HD_LEN,
                                ceil_div(MIN_LOW_NS, SYS_CLK_NS) - HD_LEN);
  localparam int LSU_LEN = max3(ceil_div(LATCH_SU_NS, SYS_CLK_NS), 1, 1);
  localparam int LPW_LEN = max3(ceil_div(LATCH_PW_NS, SYS_CLK_NS), 1, 1);
  localparam int LEN_MAX = max3(max3(HI_LEN, HD_LEN, SU_LEN), LSU_LEN, LPW_LEN);
  localparam int TMR_W   = $clog2(LEN_MAX + 1);

  prog_state_e      state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             accept, shift_adv, bit_msb, bit_last;

  assign accept = code_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    shift_adv = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(SU_LEN - 1);
      end
      ST_SETUP: if (tmr_zero) begin
        state_d = ST_HIGH; tmr_load = 1'b1; tmr_val = TMR_W'(HI_LEN - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        state_d = ST_HOLD; tmr_load = 1'b1; tmr_val = TMR_W'(HD_LEN - 1);
      end
      ST_HOLD: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bit_last) begin
          state_d = ST_LSU; tmr_val = TMR_W'(LSU_LEN - 1);
        end else begin
          state_d = ST_SETUP; tmr_val = TMR_W'(SU_LEN - 1); shift_adv = 1'b1;
        end
      end
      ST_LSU: if (tmr_zero) begin
        state_d = ST_LHI; tmr_load = 1'b1; tmr_val = TMR_W'(LPW_LEN - 1);
      end
      ST_LHI:  if (tmr_zero) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  atten_phase_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  atten_bit_shifter #(.WIDTH(CODE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (code_data),
    .advance   (shift_adv),
    .msb       (bit_msb),
    .last_bit  (bit_last)
  );

  assign code_ready = (state_q == ST_IDLE);
  assign ser_clk    = (state_q == ST_HIGH);
  assign ser_latch  = (state_q == ST_LHI);
  assign word_done  = (state_q == ST_DONE);
  assign ser_data   = bit_msb && (state_q inside {ST_SETUP, ST_HIGH, ST_HOLD, ST_LSU, ST_LHI});
endmodule

// File: rtl/atten_serial_prog_chk.sv
module atten_serial_prog_chk (
  input logic clk,
  input logic rst_n,
  input logic code_valid,
  input logic code_ready,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_latch,
  input logic word_done
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_ready) |=> !code_ready);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready |-> (!ser_clk && !ser_latch && !ser_data && !word_done));

  assert_data_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  assert_data_steady_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> $stable(ser_data));

  assert_latch_low_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !ser_latch);

  assert_latch_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_latch) |-> !$past(ser_clk));

  assert_done_follows_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_latch) |-> word_done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (!word_done && code_ready));
endmodule

bind atten_serial_prog atten_serial_prog_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_valid (code_valid),
  .code_ready (code_ready),
  .ser_clk    (ser_clk),
  .ser_data   (ser_data),
  .ser_latch  (ser_latch),
  .word_done  (word_done)
);

// File: tb/atten_serial_prog_tb.sv
module atten_serial_prog_tb;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_valid = 1'b0;
  logic [5:0] code_data = '0;
  logic       code_ready, ser_clk, ser_data, ser_latch, word_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [5:0] exp_q[$];

  always #2 clk = ~clk;

  atten_serial_prog #(.CODE_W(6), .SYS_CLK_NS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ready(code_ready),
    .code_data(code_data), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .word_done(word_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: hand one code over, push it as expected
  task automatic send(input logic [5:0] c);
    @(negedge clk);
    code_valid = 1'b1;
    code_data  = c;
    exp_q.push_back(c);
    @(posedge clk);
    while (!code_ready) @(posedge clk);
    @(negedge clk);
    check(!code_ready, "R1 ready after accept", int'(code_ready), 0);
    code_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!code_ready || exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: attenuator model plus timing measurement
  int   cyc = 0, rise_c = -1000, fall_c = -1000, chg_c = -1000, lrise_c = -1000;
  int   rises = 0;
  bit   prev_clk = 0, prev_dat = 0, prev_le = 0, prev_done = 0, had_fall = 0;
  logic [5:0] sr = '0, latched = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (ser_data != prev_dat) begin
        check(!ser_clk, "R5 data change while clock high", 1, 0);
        if (had_fall) check((cyc - fall_c) * P >= 10, "R5 hold ns", (cyc - fall_c) * P, 10);
        chg_c = cyc;
      end
      if (ser_clk && !prev_clk) begin
        check((cyc - chg_c) * P >= 10, "R5 setup ns", (cyc - chg_c) * P, 10);
        check(!ser_latch, "R6 latch low at rise", int'(ser_latch), 0);
        if (had_fall) begin
          check((cyc - fall_c) * P >= 30, "R4 low ns", (cyc - fall_c) * P, 30);
          check((cyc - rise_c) * P >= 100, "R4 period ns", (cyc - rise_c) * P, 100);
        end
        sr = {sr[4:0], ser_data};
        rises++;
        rise_c = cyc;
      end
      if (!ser_clk && prev_clk) begin
        check((cyc - rise_c) * P >= 30, "R4 high ns", (cyc - rise_c) * P, 30);
        fall_c = cyc;
        had_fall = 1;
      end
      if (ser_latch && !prev_le) begin
        check(rises == 6, "R3 R6 edges before latch", rises, 6);
        check((cyc - fall_c) * P >= 10, "R7 latch setup ns", (cyc - fall_c) * P, 10);
        latched = sr;
        lrise_c = cyc;
      end
      if (!ser_latch && prev_le) begin
        check((cyc - lrise_c) * P >= 30, "R8 latch width ns", (cyc - lrise_c) * P, 30);
        check(word_done, "R9 done with latch fall", int'(word_done), 1);
        if (exp_q.size() == 0) begin
          check(0, "R1 unexpected word latched", int'(latched), -1);
        end else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          check(latched == e, "R3 latched word", int'(latched), int'(e));
        end
        rises = 0;
        had_fall = 0;
      end
      if (word_done && prev_le == 0 && !(prev_done)) begin
        // done without a latch fall in this cycle is caught here
        check(0, "R9 done without latch", 1, 0);
      end
      if (prev_done) begin
        check(!word_done, "R9 done one cycle", int'(word_done), 0);
        check(code_ready, "R9 ready after done", int'(code_ready), 1);
        check(!ser_clk && !ser_data && !ser_latch, "R2 idle outputs low",
              int'({ser_clk, ser_data, ser_latch}), 0);
      end
      prev_clk = ser_clk; prev_dat = ser_data; prev_le = ser_latch; prev_done = word_done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(code_ready, "R2 reset ready", int'(code_ready), 1);
    check(!ser_clk && !ser_data && !ser_latch && !word_done, "R2 reset outputs",
          int'({ser_clk, ser_data, ser_latch, word_done}), 0);
    rst_n = 1'b1;
    send(6'h20); wait_idle();
    send(6'h01); wait_idle();
    send(6'h00); wait_idle();
    send(6'h3F); wait_idle();
    send(6'h2A); wait_idle();
    send(6'h15); wait_idle();
    // back-pressure: second request held while the first runs
    send(6'h33);
    send(6'h0C);
    wait_idle();
    // a request pulsed and withdrawn while busy must be ignored
    send(6'h27);
    repeat (20) @(negedge clk);
    check(!code_ready, "R1 busy", int'(code_ready), 0);
    code_valid = 1'b1; code_data = 6'h11;
    repeat (5) @(negedge clk);
    code_valid = 1'b0; code_data = '0;
    wait_idle();
    repeat (300) @(negedge clk);
    check(exp_q.size() == 0, "R1 no extra word", exp_q.size(), 0);
    check(!ser_latch && code_ready, "R1 R2 idle after ignored request",
          int'({ser_latch, code_ready}), 1);
    finish_run();
  end
endmodule